// File: doc/BRIEF.md
# Serial Real-Time Clock Slave

This block is the clock-and-memory peripheral that a host reaches over a bit-banged, three-signal link: an enable level, a serial clock and one data line. The host toggles these from a system control register. While enable is high, each falling edge of the serial clock moves one bit. A frame has sixteen bits. The first eight form a command byte and the last eight form a value byte, both most significant bit first.

The command byte selects the operation by its code range. The operations are a read or a write of a small battery-backed byte store, a read of a status byte or a control byte, a read of a packed-BCD time-of-day field, and a write that acknowledges a power-fail condition. Read data leaves on `ser_dout` during the value half of the frame. For any other command, and outside the value half, `ser_dout` simply follows `ser_din`. A time-of-day counter runs from a once-per-second tick and carries through seconds, minutes, hours, day of month, month and year.

Top module: `rtc_serial_slave`

## Requirements
- R1: Bits are taken only on a falling edge of `ser_clk` and only while `ser_en` is high. Rising edges, and any edges while enable is low, change nothing.
- R2: Frame bits 0–7 fill the command byte and bits 8–15 fill the value byte, both most significant bit first.
- R3: Lowering `ser_en` aborts the frame. The bit count and both bytes return to zero, and a write that has not reached its 16th bit is discarded.
- R4: A command of 0x00–0x1F reads store byte [command]. While the frame is at bit 8+k (k = 0..7), `ser_dout` carries bit 7−k of that byte.
- R5: A command of 0x80–0x9F writes the value byte into store byte [command − 0x80] when the 16th bit completes.
- R6: Command 0x30 reads the status byte, which resets to 0x90. Command 0x31 reads the control byte, which is 0x00.
- R7: Commands 0x20, 0x21, 0x22, 0x24, 0x25 and 0x26 return seconds, minutes, hours, day, month and year as packed BCD. The other codes from 0x20 to 0x2F return 0x00.
- R8: Command 0xB1 whose value has bit 2 set clears status bits 4 and 3 and raises `pf_irq_clr` for exactly one cycle. With bit 2 clear it does nothing.
- R9: Any command outside the ranges above changes no state, and `ser_dout` equals `ser_din` throughout that frame.
- R10: After the 16th bit, further clock edges are ignored until enable is lowered and raised again. During that time `ser_dout` equals `ser_din`.
- R11: Each cycle with `sec_tick` high advances the time by one second with BCD carry. Seconds and minutes wrap after 59 and hours wrap after 23. Day wraps after DAY_LIMIT back to 1 and carries into the month. Month wraps after 12 to 1 and carries into the two-digit year.
- R12: After reset, all store bytes are 0x00. The time reads 00:00:00, day 01, month 01, year 00, and `pf_irq_clr` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second advance strobe, one cycle per second |
| ser_en | input | 1 | Frame enable level from the host |
| ser_clk | input | 1 | Serial clock from the host, synchronous to `clk` |
| ser_din | input | 1 | Serial data written by the host |
| ser_dout | output | 1 | Serial data seen by the host |
| pf_irq_clr | output | 1 | One-cycle pulse that clears the power-fail interrupt |

## Verification
The bench builds the block with a 32-byte store and DAY_LIMIT set to 1. With a one-day month, one day of ticks (86,400 cycles) is enough to carry a rollover from 23:59:59 through the day field into the month. Along the way it passes the minute and hour carries, and every one of the sixteen time codes is read at each stop. A full 32-address write and read sweep with asymmetric byte patterns exercises both ends of the store and the bit order of the serial link. Aborted frames, frames that run past sixteen bits, ignored command codes and both forms of the acknowledge write are then checked against an arithmetic model of the time.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;

   localparam int BYTE_W     = 8;
   localparam int NUM_FIELDS = 6;   // sec, min, hour, day, month, year

   // status bits cleared by the acknowledge write, and the value bit that triggers it
   localparam logic [BYTE_W-1:0] PF_MASK    = 8'h18;
   localparam int                PF_ACK_BIT = 2;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_RAM_RD,
      OP_RAM_WR,
      OP_STAT_RD,
      OP_CTRL_RD,
      OP_TIME_RD,
      OP_STAT_WR
   } rtc_op_e;

   function automatic rtc_op_e decode_op(input logic [BYTE_W-1:0] code);
      rtc_op_e op;
      if (code[7:5] == 3'b000)      op = OP_RAM_RD;
      else if (code[7:5] == 3'b100) op = OP_RAM_WR;
      else if (code[7:4] == 4'h2)   op = OP_TIME_RD;
      else if (code == 8'h30)       op = OP_STAT_RD;
      else if (code == 8'h31)       op = OP_CTRL_RD;
      else if (code == 8'hB1)       op = OP_STAT_WR;
      else                          op = OP_NONE;
      return op;
   endfunction

   function automatic int field_min(input int idx);
      return (idx == 3 || idx == 4) ? 1 : 0;
   endfunction

   function automatic int field_max(input int idx, input int day_limit);
      int m;
      case (idx)
         0, 1:    m = 59;
         2:       m = 23;
         3:       m = day_limit;
         4:       m = 12;
         default: m = 99;
      endcase
      return m;
   endfunction

   function automatic logic [BYTE_W-1:0] to_bcd(input int v);
      logic [3:0] hi;
      logic [3:0] lo;
      hi = 4'(v / 10);
      lo = 4'(v % 10);
      return {hi, lo};
   endfunction

endpackage

// File: rtl/rtc_frame.sv
module rtc_frame #(
   parameter int BITS = 8,
   localparam int PH_W = $clog2(2*BITS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            sclk,
   input  logic            din,
   output logic [PH_W-1:0] phase,
   output logic [BITS-1:0] cmd,
   output logic [BITS-1:0] val,
   output logic            commit
);
   localparam logic [PH_W-1:0] HALF_PH = PH_W'(BITS);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(2*BITS);

   if (BITS < 2) begin : g_bad_bits
      $error("rtc_frame: BITS must be at least 2");
   end

   logic clk_q;
   logic fall;

   assign fall = clk_q & ~sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q  <= 1'b0;
         phase  <= '0;
         cmd    <= '0;
         val    <= '0;
         commit <= 1'b0;
      end else begin
         clk_q  <= sclk;
         commit <= 1'b0;
         if (!en) begin
            phase <= '0;
            cmd   <= '0;
            val   <= '0;
         end else if (fall && phase != LAST_PH) begin
            phase <= phase + 1'b1;
            if (phase < HALF_PH) cmd <= {cmd[BITS-2:0], din};
            else                 val <= {val[BITS-2:0], din};
            if (phase == LAST_PH - 1'b1) commit <= 1'b1;
         end
      end
   end

   assert_abort_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (phase == '0 && cmd == '0 && val == '0));

   assert_falling_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !fall) |=> ($stable(phase) && $stable(cmd) && $stable(val)));

   assert_frozen_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == LAST_PH) |=> (phase == LAST_PH && $stable(cmd) && $stable(val)));

   assert_phase_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= LAST_PH);

   assert_commit_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> phase == LAST_PH);

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_ser_pkg::*;
#(
   parameter int MIN_VAL = 0,
   parameter int MAX_VAL = 59
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [BYTE_W-1:0] value,
   output logic              at_max
);
   localparam logic [BYTE_W-1:0] MIN_BCD = to_bcd(MIN_VAL);
   localparam logic [BYTE_W-1:0] MAX_BCD = to_bcd(MAX_VAL);

   if (MIN_VAL < 0 || MAX_VAL > 99 || MIN_VAL > MAX_VAL) begin : g_bad_range
      $error("rtc_bcd_field: range must lie within 0..99 with MIN_VAL <= MAX_VAL");
   end

   assign at_max = (value == MAX_BCD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 value <= MIN_BCD;
      else if (step) begin
         if (at_max)              value <= MIN_BCD;
         else if (value[3:0] == 4'd9) value <= {value[7:4] + 4'd1, 4'd0};
         else                     value <= value + 8'd1;
      end
   end

   assert_bcd_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (value[3:0] <= 4'd9 && value <= MAX_BCD && value >= MIN_BCD));

   assert_bcd_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (step && at_max) |=> value == MIN_BCD);

endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
   import rtc_ser_pkg::*;
#(
   parameter int DAY_LIMIT = 31
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             sec_tick,
   output logic [NUM_FIELDS-1:0][BYTE_W-1:0] fields
);
   logic [NUM_FIELDS:0]   carry;
   logic [NUM_FIELDS-1:0] at_max;
   logic                  year_wrap_unused;

   assign carry[0]         = sec_tick;
   assign year_wrap_unused = carry[NUM_FIELDS];

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      rtc_bcd_field #(
         .MIN_VAL(field_min(i)),
         .MAX_VAL(field_max(i, DAY_LIMIT))
      ) u_field (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (carry[i]),
         .value  (fields[i]),
         .at_max (at_max[i])
      );
      assign carry[i+1] = carry[i] & at_max[i];
   end

endmodule

// File: rtl/rtc_nvram.sv
module rtc_nvram
   import rtc_ser_pkg::*;
#(
   parameter int DEPTH = 32,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata
);
   logic [BYTE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
   import rtc_ser_pkg::*;
#(
   parameter int                RAM_DEPTH     = 32,
   parameter int                DAY_LIMIT     = 31,
   parameter logic [BYTE_W-1:0] STATUS_RESET  = 8'h90,
   parameter logic [BYTE_W-1:0] CONTROL_VALUE = 8'h00
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic ser_en,
   input  logic ser_clk,
   input  logic ser_din,
   output logic ser_dout,
   output logic pf_irq_clr
);
   localparam int ADDR_W = $clog2(RAM_DEPTH);
   localparam int PH_W   = $clog2(2*BYTE_W + 1);
   localparam int IDX_W  = $clog2(BYTE_W);
   localparam logic [PH_W-1:0] HALF_PH = PH_W'(BYTE_W);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(2*BYTE_W);
   localparam logic [PH_W-1:0] TOP_PH  = PH_W'(2*BYTE_W - 1);

   if (RAM_DEPTH < 2 || RAM_DEPTH > 32 || (RAM_DEPTH & (RAM_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rtc_serial_slave: RAM_DEPTH must be a power of two from 2 to 32");
   end
   if (DAY_LIMIT < 1 || DAY_LIMIT > 31) begin : g_bad_days
      $error("rtc_serial_slave: DAY_LIMIT must lie within 1..31");
   end

   logic [PH_W-1:0]                  phase;
   logic [BYTE_W-1:0]                cmd;
   logic [BYTE_W-1:0]                val;
   logic                             commit;
   rtc_op_e                          op;
   logic                             ram_hit;
   logic                             ram_we;
   logic [BYTE_W-1:0]                ram_rdata;
   logic [NUM_FIELDS-1:0][BYTE_W-1:0] tod;
   logic [BYTE_W-1:0]                time_byte;
   logic [BYTE_W-1:0]                rd_byte;
   logic [BYTE_W-1:0]                status;
   logic                             is_read;
   logic                             data_phase;
   logic [IDX_W-1:0]                 bit_sel;

   rtc_frame #(.BITS(BYTE_W)) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ser_en),
      .sclk   (ser_clk),
      .din    (ser_din),
      .phase  (phase),
      .cmd    (cmd),
      .val    (val),
      .commit (commit)
   );

   rtc_tod #(.DAY_LIMIT(DAY_LIMIT)) u_tod (
      .clk      (clk),
      .rst_n    (rst_n),
      .sec_tick (sec_tick),
      .fields   (tod)
   );

   // store addresses above the configured depth are not backed
   if (ADDR_W == 5) begin : g_full_store
      assign ram_hit = 1'b1;
   end else begin : g_part_store
      assign ram_hit = (cmd[4:ADDR_W] == '0);
   end

   assign op     = decode_op(cmd);
   assign ram_we = commit && op == OP_RAM_WR && ram_hit;

   rtc_nvram #(.DEPTH(RAM_DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ram_we),
      .addr  (cmd[ADDR_W-1:0]),
      .wdata (val),
      .rdata (ram_rdata)
   );

   always_comb begin
      case (cmd[3:0])
         4'h0:    time_byte = tod[0];
         4'h1:    time_byte = tod[1];
         4'h2:    time_byte = tod[2];
         4'h4:    time_byte = tod[3];
         4'h5:    time_byte = tod[4];
         4'h6:    time_byte = tod[5];
         default: time_byte = '0;
      endcase
   end

   always_comb begin
      case (op)
         OP_RAM_RD:  rd_byte = ram_hit ? ram_rdata : '0;
         OP_STAT_RD: rd_byte = status;
         OP_CTRL_RD: rd_byte = CONTROL_VALUE;
         OP_TIME_RD: rd_byte = time_byte;
         default:    rd_byte = '0;
      endcase
   end

   assign is_read    = op inside {OP_RAM_RD, OP_STAT_RD, OP_CTRL_RD, OP_TIME_RD};
   assign data_phase = (phase >= HALF_PH) && (phase < LAST_PH);
   assign bit_sel    = IDX_W'(TOP_PH - phase);
   assign ser_dout   = (is_read && data_phase) ? rd_byte[bit_sel] : ser_din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status     <= STATUS_RESET;
         pf_irq_clr <= 1'b0;
      end else begin
         pf_irq_clr <= 1'b0;
         if (commit && op == OP_STAT_WR && val[PF_ACK_BIT]) begin
            status     <= status & ~PF_MASK;
            pf_irq_clr <= 1'b1;
         end
      end
   end

   assert_clr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pf_irq_clr |=> !pf_irq_clr);

   assert_clr_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pf_irq_clr |-> (status & PF_MASK) == '0);

   assert_store_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && op == OP_RAM_WR && ram_hit && ser_en) |=> ram_rdata == $past(val));

endmodule

// File: tb/test_rtc_serial_slave.sv
module test_rtc_serial_slave;
   localparam int DAYS = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_tick = 1'b0;
   logic ser_en = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_din = 1'b0;
   logic ser_dout;
   logic pf_irq_clr;

   int n_checks = 0;
   int n_fail = 0;
   int n_pulse = 0;
   bit done = 1'b0;
   int t_s = 0, t_m = 0, t_h = 0, t_d = 1, t_mo = 1, t_y = 0;

   always #2 clk = ~clk;

   rtc_serial_slave #(.DAY_LIMIT(DAYS)) i_rtc_serial_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .sec_tick   (sec_tick),
      .ser_en     (ser_en),
      .ser_clk    (ser_clk),
      .ser_din    (ser_din),
      .ser_dout   (ser_dout),
      .pf_irq_clr (pf_irq_clr)
   );

   always @(negedge clk) if (rst_n && pf_irq_clr) n_pulse++;

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] pat(input int i);
      return 8'((i * 37 + 11) ^ 8'h5C);
   endfunction

   function automatic logic [7:0] exp_time(input int code);
      case (code)
         0: return bcd(t_s);
         1: return bcd(t_m);
         2: return bcd(t_h);
         4: return bcd(t_d);
         5: return bcd(t_mo);
         6: return bcd(t_y);
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // host drives a wrong level at the rising edge, the real bit before the falling edge
   task automatic send_bit(input logic d, output logic o);
      ser_clk = 1'b1; ser_din = ~d;
      @(negedge clk);
      ser_din = d;
      @(negedge clk);
      o = ser_dout;
      ser_clk = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send_bits(input logic [15:0] bits, input int n, output logic [15:0] got);
      logic o;
      got = '0;
      for (int i = 0; i < n; i++) begin
         send_bit(bits[15-i], o);
         got[15-i] = o;
      end
   endtask

   task automatic open_frame();
      ser_en = 1'b1;
      @(negedge clk);
   endtask

   task automatic close_frame();
      ser_en = 1'b0; ser_clk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] c, input logic [7:0] v, output logic [7:0] r);
      logic [15:0] g;
      open_frame();
      send_bits({c, v}, 16, g);
      close_frame();
      r = g[7:0];
   endtask

   task automatic step_model();
      t_s++;
      if (t_s == 60) begin
         t_s = 0; t_m++;
         if (t_m == 60) begin
            t_m = 0; t_h++;
            if (t_h == 24) begin
               t_h = 0; t_d++;
               if (t_d > DAYS) begin
                  t_d = 1; t_mo++;
                  if (t_mo > 12) begin t_mo = 1; t_y = (t_y + 1) % 100; end
               end
            end
         end
      end
   endtask

   task automatic ticks(input int n);
      sec_tick = 1'b1;
      repeat (n) @(negedge clk);
      sec_tick = 1'b0;
      @(negedge clk);
      for (int i = 0; i < n; i++) step_model();
   endtask

   task automatic check_time(input string tag);
      logic [7:0] r;
      for (int c = 0; c < 16; c++) begin
         xfer(8'(8'h20 + c), 8'h00, r);
         check(tag, r, exp_time(c));
      end
   endtask

   initial begin
      logic [7:0]  r;
      logic [15:0] g;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state at the ports
      check("R12 idle pf_irq_clr", {7'b0, pf_irq_clr}, 8'h00);
      check("R12 idle dout", {7'b0, ser_dout}, {7'b0, ser_din});
      xfer(8'h30, 8'h00, r); check("R6 R12 status reset", r, 8'h90);
      xfer(8'h31, 8'h00, r); check("R6 control", r, 8'h00);
      for (int i = 0; i < 32; i++) begin
         xfer(8'(i), 8'h00, r); check("R12 store clear", r, 8'h00);
      end
      check_time("R7 R12 reset time");

      // R5, R4, R2: write then read back every address, MSB first on the wire
      for (int i = 0; i < 32; i++) begin
         xfer(8'(8'h80 + i), pat(i), r);
         check("R9 write frame passthrough", r, pat(i));
      end
      for (int i = 0; i < 32; i++) begin
         xfer(8'(i), 8'h00, r); check("R4 R5 R2 store readback", r, pat(i));
      end

      // R1: edges with enable low do nothing
      ser_en = 1'b0;
      send_bits({8'h80, 8'hFF}, 16, g);
      close_frame();
      xfer(8'h00, 8'h00, r); check("R1 disabled clocking", r, pat(0));

      // R9: unused codes change nothing and release the line
      xfer(8'h40, 8'h5A, r); check("R9 code 40 passthrough", r, 8'h5A);
      xfer(8'h55, 8'hC3, r); check("R9 code 55 passthrough", r, 8'hC3);
      xfer(8'hA0, 8'h3C, r); check("R9 code A0 passthrough", r, 8'h3C);
      xfer(8'h00, 8'h00, r); check("R9 store untouched", r, pat(0));
      xfer(8'h30, 8'h00, r); check("R9 status untouched", r, 8'h90);

      // R3: aborted write is discarded
      open_frame();
      send_bits({8'h86, 8'h77}, 12, g);
      close_frame();
      xfer(8'h06, 8'h00, r); check("R3 aborted write", r, pat(6));
      open_frame();
      send_bits({8'h9F, 8'h00}, 15, g);
      close_frame();
      xfer(8'h1F, 8'h00, r); check("R3 abort at bit 15", r, pat(31));

      // R10: bits beyond the sixteenth are ignored until enable is cycled
      open_frame();
      send_bits({8'h05, 8'h00}, 16, g);
      check("R10 R4 first read", g[7:0], pat(5));
      send_bits({8'h85, 8'hEE}, 16, g);
      check("R10 overrun passthrough", g[7:0], 8'hEE);
      close_frame();
      xfer(8'h05, 8'h00, r); check("R10 no overrun write", r, pat(5));

      // R8: acknowledge write
      xfer(8'hB1, 8'hFB, r);
      check("R8 no ack pulse", 8'(n_pulse), 8'd0);
      xfer(8'h30, 8'h00, r); check("R8 status kept", r, 8'h90);
      xfer(8'hB1, 8'h04, r);
      check("R8 ack pulse", 8'(n_pulse), 8'd1);
      xfer(8'h30, 8'h00, r); check("R8 status cleared", r, 8'h80);
      xfer(8'hB1, 8'hFF, r);
      check("R8 second pulse", 8'(n_pulse), 8'd2);
      xfer(8'h30, 8'h00, r); check("R8 status stays", r, 8'h80);

      // R11, R7: time-of-day carries
      ticks(59);    check_time("R11 R7 at 59 s");
      ticks(1);     check_time("R11 minute carry");
      ticks(3540);  check_time("R11 hour carry");
      ticks(82799); check_time("R11 end of day");
      ticks(1);     check_time("R11 day into month");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule